// File: doc/BRIEF.md
# Region-Mode Data Cache Controller

This block is a direct-mapped data cache that sits between a processor load/store port and a plain word-wide memory bus. Every access comes with a region flag that selects one of two policies. In copyback regions, a write miss first brings the whole line in and then merges the store, and later stores only mark the line dirty. In write-through regions, a store always reaches memory as a single word and never allocates a line. Lines are 16 bytes, which is four 32-bit words, and they are filled or written back as four consecutive single-word bus transfers.

The core raises `cpuReq` and holds the address, data and flags steady until `cpuReady` pulses. A read hit, or a copyback write hit, completes in the cycle it is presented. Two maintenance commands are each accepted as a one-cycle pulse while the controller is idle. The first invalidates every line and drops any modified data. The second pushes one line: if that line is modified it is written back, then the line is invalidated, and a done pulse is raised. Each memory bus transfer is held on the bus until the memory returns a one-cycle acknowledge.

Top module: `regioncache`

## Requirements
- R1: After reset the controller is idle, with `cpuReady`, `memReq` and `pushDone` low and every line invalid.
- R2: A read miss fetches the four words of the line. The fetches go in word order, at line offsets 0x0, 0x4, 0x8 and 0xC, with `memWe` low. The requested word is then returned with `cpuReady`, and the line is left valid and clean.
- R3: A read hit returns the cached word with no bus traffic.
- R4: A copyback write miss (`cpuWthru`=0) fills the line before the store is merged. It performs four reads and no memory write, and memory keeps its old value until the line is evicted.
- R5: A copyback write hit merges only the bytes whose `cpuBe` bit is set (bit n covers data bits 8n+7..8n). It creates no bus traffic and marks the line modified.
- R6: A miss that lands on a valid modified line first writes the four old words back to their own addresses, and only then fills the line.
- R7: A write-through write miss (`cpuWthru`=1) issues exactly one memory write carrying the store's byte enables. It allocates nothing, so a later read of that address misses.
- R8: A write-through write hit updates the cached word and issues exactly one memory write. The line stays clean, so pushing it later writes nothing.
- R9: A read hit on a modified line causes no write-back, even when the access is flagged write-through. The line stays modified.
- R10: A push command (`pushReq` with `pushIdx`) on a modified line writes its four words back. On a clean line it writes nothing. In both cases the line is invalidated and `pushDone` pulses once.
- R11: An invalidate-all command (`invAll`) makes every line invalid and discards modified data without writing it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Core access request, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuWthru | input | 1 | Region policy: 1 = write-through, 0 = copyback |
| cpuAddr | input | ADDR_W | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuBe | input | 4 | Store byte enables |
| cpuReady | output | 1 | Access completes this cycle |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| invAll | input | 1 | Invalidate-all command pulse |
| pushReq | input | 1 | Push-line command pulse |
| pushIdx | input | IDX_W | Line index for the push command |
| pushDone | output | 1 | Push command finished |
| memReq | output | 1 | Bus transfer request |
| memWe | output | 1 | Bus transfer is a write |
| memAddr | output | ADDR_W | Word-aligned bus address |
| memWdata | output | 32 | Bus write data |
| memBe | output | 4 | Bus write byte enables |
| memAck | input | 1 | Memory accepts or answers the transfer |
| memRdata | input | 32 | Bus read data, valid with memAck |

## Verification
The hardest case to reach is a modified line that is read through a write-through access and is still modified afterwards. From the ports, the only proof is the write traffic it causes later. The stimulus first dirties a line with a copyback store. It then reads the same line with the region flag set and checks for zero bus traffic, and then pushes the line and expects exactly four writes carrying the dirty data. The same approach, a later push or eviction used as a probe, is how the tests show that a write-through hit leaves the line clean and that invalidate-all drops modified data.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int WORDS_PER_LINE = 4;
  localparam int OFF_W = 2;

  typedef struct packed {
    logic wrCpu;     // merge core store into cached word
    logic fillWr;    // write bus word into line
    logic setLine;   // mark line valid, clean, new tag
    logic setDirty;  // mark line modified
    logic clrLine;   // invalidate one line
    logic clrAll;    // invalidate every line
  } rcStrobes;
endpackage

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 25
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rcStrobes                 st,
  input  logic [$clog2(LINES)-1:0] idx,
  input  logic [OFF_W-1:0]         wordSel,
  input  logic [TAG_W-1:0]         newTag,
  input  logic [31:0]              cpuWdata,
  input  logic [3:0]               cpuBe,
  input  logic [31:0]              memRdata,
  output logic                     lineVld,
  output logic                     lineDirty,
  output logic [TAG_W-1:0]         lineTag,
  output logic [31:0]              rdWord
);
  localparam int IDX_W = $clog2(LINES);
  localparam int NWORDS = LINES * WORDS_PER_LINE;

  logic [LINES-1:0] vld, dirty;
  logic [TAG_W-1:0] tags [LINES];
  logic [31:0]      words [NWORDS];
  logic [IDX_W+OFF_W-1:0] wAddr;

  assign wAddr     = {idx, wordSel};
  assign lineVld   = vld[idx];
  assign lineDirty = dirty[idx];
  assign lineTag   = tags[idx];
  assign rdWord    = words[wAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld   <= '0;
      dirty <= '0;
    end else if (st.clrAll) begin
      vld   <= '0;
      dirty <= '0;
    end else begin
      if (st.clrLine) begin
        vld[idx]   <= 1'b0;
        dirty[idx] <= 1'b0;
      end else if (st.setLine) begin
        vld[idx]   <= 1'b1;
        dirty[idx] <= 1'b0;
      end
      if (st.setDirty) dirty[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.setLine) tags[idx] <= newTag;
    if (st.fillWr) begin
      words[wAddr] <= memRdata;
    end else if (st.wrCpu) begin
      for (int b = 0; b < 4; b++)
        if (cpuBe[b]) words[wAddr][8*b +: 8] <= cpuWdata[8*b +: 8];
    end
  end

  AST_NO_MERGE_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCpu |-> vld[idx]); // R4
  AST_FILL_INTO_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    st.fillWr |-> !vld[idx]); // R2
  AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (dirty & ~vld) == '0); // R5
endmodule

// File: rtl/rc_control.sv
module rc_control
  import rc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8,
  parameter int TAG_W  = 25
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic                     cpuWthru,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [31:0]              cpuWdata,
  input  logic [3:0]               cpuBe,
  output logic                     cpuReady,
  output logic [31:0]              cpuRdata,
  input  logic                     invAll,
  input  logic                     pushReq,
  input  logic [$clog2(LINES)-1:0] pushIdx,
  output logic                     pushDone,
  output logic                     memReq,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [31:0]              memWdata,
  output logic [3:0]               memBe,
  input  logic                     memAck,
  output rcStrobes                 st,
  output logic [$clog2(LINES)-1:0] idx,
  output logic [OFF_W-1:0]         wordSel,
  output logic [TAG_W-1:0]         cpuTag,
  input  logic                     lineVld,
  input  logic                     lineDirty,
  input  logic [TAG_W-1:0]         lineTag,
  input  logic [31:0]              rdWord
);
  localparam int IDX_W = $clog2(LINES);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_WTWR} stateT;
  stateT state, stateNx;
  logic [OFF_W-1:0] cnt;
  logic             pushing, pushingNx;
  logic [IDX_W-1:0] pushIdxQ;
  logic [IDX_W-1:0] cpuIdx;
  logic [OFF_W-1:0] cpuWord;
  logic             hit, lastWord, unusedAddr;

  assign cpuIdx     = cpuAddr[IDX_W+OFF_W+1:OFF_W+2];
  assign cpuTag     = cpuAddr[ADDR_W-1:IDX_W+OFF_W+2];
  assign cpuWord    = cpuAddr[OFF_W+1:2];
  assign unusedAddr = ^cpuAddr[1:0];
  assign hit        = lineVld && (lineTag == cpuTag);
  assign lastWord   = (cnt == OFF_W'(WORDS_PER_LINE - 1));
  assign cpuRdata   = rdWord;

  always_comb begin
    stateNx   = state;
    pushingNx = pushing;
    st        = '0;
    cpuReady  = 1'b0;
    pushDone  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memAddr   = '0;
    memWdata  = '0;
    memBe     = 4'h0;
    idx       = cpuIdx;
    wordSel   = cpuWord;
    unique case (state)
      S_IDLE: begin
        if (invAll) begin
          st.clrAll = 1'b1;
        end else if (pushReq) begin
          idx = pushIdx;
          if (lineVld && lineDirty) begin
            stateNx   = S_WB;
            pushingNx = 1'b1;
          end else begin
            st.clrLine = 1'b1;
            pushDone   = 1'b1;
          end
        end else if (cpuReq) begin
          if (cpuWe && cpuWthru) begin
            st.wrCpu = hit;
            stateNx  = S_WTWR;
          end else if (hit) begin
            cpuReady    = 1'b1;
            st.wrCpu    = cpuWe;
            st.setDirty = cpuWe;
          end else if (lineVld && lineDirty) begin
            stateNx = S_WB;
          end else begin
            st.clrLine = 1'b1;
            stateNx    = S_FILL;
          end
        end
      end
      S_WB: begin
        idx      = pushing ? pushIdxQ : cpuIdx;
        wordSel  = cnt;
        memReq   = 1'b1;
        memWe    = 1'b1;
        memAddr  = ADDR_W'({lineTag, idx, cnt, 2'b00});
        memWdata = rdWord;
        memBe    = 4'hF;
        if (memAck && lastWord) begin
          st.clrLine = 1'b1;
          pushDone   = pushing;
          stateNx    = pushing ? S_IDLE : S_FILL;
          pushingNx  = 1'b0;
        end
      end
      S_FILL: begin
        wordSel   = cnt;
        memReq    = 1'b1;
        memAddr   = ADDR_W'({cpuTag, cpuIdx, cnt, 2'b00});
        st.fillWr = memAck;
        if (memAck && lastWord) begin
          st.setLine = 1'b1;
          stateNx    = S_IDLE;
        end
      end
      S_WTWR: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        memAddr  = {cpuAddr[ADDR_W-1:2], 2'b00};
        memWdata = cpuWdata;
        memBe    = cpuBe;
        if (memAck) begin
          cpuReady = 1'b1;
          stateNx  = S_IDLE;
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      pushing  <= 1'b0;
      pushIdxQ <= '0;
    end else begin
      state   <= stateNx;
      pushing <= pushingNx;
      if (state == S_IDLE && pushReq && !invAll) pushIdxQ <= pushIdx;
      if ((state == S_WB || state == S_FILL) && memAck) cnt <= cnt + 1'b1;
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr)); // R2
  AST_WT_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuWe && cpuWthru |-> memAck); // R7
endmodule

// File: rtl/regioncache.sv
module regioncache
  import rc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuWthru,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  input  logic [3:0]        cpuBe,
  output logic              cpuReady,
  output logic [31:0]       cpuRdata,
  input  logic              invAll,
  input  logic              pushReq,
  input  logic [IDX_W-1:0]  pushIdx,
  output logic              pushDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic              memAck,
  input  logic [31:0]       memRdata
);
  rcStrobes         st;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] wordSel;
  logic [TAG_W-1:0] cpuTag, lineTag;
  logic             lineVld, lineDirty;
  logic [31:0]      rdWord;

  rc_control #(.ADDR_W(ADDR_W), .LINES(LINES), .TAG_W(TAG_W)) ctrl (
    .clk, .rstN, .cpuReq, .cpuWe, .cpuWthru, .cpuAddr, .cpuWdata, .cpuBe,
    .cpuReady, .cpuRdata, .invAll, .pushReq, .pushIdx, .pushDone,
    .memReq, .memWe, .memAddr, .memWdata, .memBe, .memAck,
    .st, .idx, .wordSel, .cpuTag, .lineVld, .lineDirty, .lineTag, .rdWord
  );

  rc_datapath #(.LINES(LINES), .TAG_W(TAG_W)) dp (
    .clk, .rstN, .st, .idx, .wordSel, .newTag(cpuTag), .cpuWdata, .cpuBe,
    .memRdata, .lineVld, .lineDirty, .lineTag, .rdWord
  );
endmodule

// File: tb/regioncache_test.sv
`timescale 1ns/100ps
module regioncache_test;
  localparam int ADDR_W = 32;
  localparam int LINES  = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuReq = 0, cpuWe = 0, cpuWthru = 0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [3:0]  cpuBe = 4'hF;
  logic cpuReady, pushDone, memReq, memWe;
  logic [31:0] cpuRdata, memWdata;
  logic [ADDR_W-1:0] memAddr;
  logic [3:0] memBe;
  logic invAll = 0, pushReq = 0;
  logic [2:0] pushIdx = '0;
  logic memAck = 0;
  logic [31:0] memRdata = '0;

  logic [31:0] mem [256];
  int rdCnt = 0, wrCnt = 0, rd0 = 0, wr0 = 0;
  int tests = 0, fails = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  bit finished = 0;

  regioncache #(.ADDR_W(ADDR_W), .LINES(LINES)) uut (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge per transfer
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (memBe[b]) mem[memAddr[9:2]][8*b +: 8] = memWdata[8*b +: 8];
          wrCnt++;
        end else begin
          memRdata <= mem[memAddr[9:2]];
          rdCnt++;
        end
      end else memAck <= 1'b0;
    end
  end

  // monitor: compares each completed load against the scoreboard
  initial forever begin
    @(negedge clk);
    #0.5;
    if (cpuReq && cpuReady && !cpuWe) begin
      if (expQ.size() == 0) check(0, "scoreboard empty", cpuRdata, 0);
      else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(cpuRdata === e, t, cpuRdata, e);
      end
    end
  end

  task automatic access(input bit we, input bit wt, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        input logic [31:0] exp, input string req);
    rd0 = rdCnt; wr0 = wrCnt;
    if (!we) begin expQ.push_back(exp); tagQ.push_back(req); end
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuWthru = wt; cpuAddr = a; cpuWdata = d; cpuBe = be;
    forever begin
      #0.8;
      if (cpuReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 0;
  endtask

  task automatic traffic(input int er, input int ew, input string req);
    check(rdCnt - rd0 == er, {req, " bus reads"}, rdCnt - rd0, er);
    check(wrCnt - wr0 == ew, {req, " bus writes"}, wrCnt - wr0, ew);
  endtask

  task automatic push(input logic [2:0] i);
    int n = 0;
    rd0 = rdCnt; wr0 = wrCnt;
    @(negedge clk);
    pushReq = 1; pushIdx = i;
    forever begin
      #0.8;
      if (pushDone) n++;
      @(negedge clk);
      pushReq = 0;
      if (n > 0 && !memReq) break;
    end
    check(n == 1, "R10 single done pulse", n, 1);
  endtask

  initial begin
    #(200000 * 4);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cpuReady && !memReq && !pushDone, "R1 reset idle", {cpuReady, memReq, pushDone}, 0);
    rstN = 1;
    // R2 read miss
    access(0, 0, 32'h48, 0, 4'hF, 32'hA000_0012, "R2 read miss data");
    traffic(4, 0, "R2");
    // R3 read hit
    access(0, 0, 32'h44, 0, 4'hF, 32'hA000_0011, "R3 read hit data");
    traffic(0, 0, "R3");
    // R4 copyback write miss (evicts clean line at index 4)
    access(1, 0, 32'hC8, 32'h1122_3344, 4'hF, 0, "R4");
    traffic(4, 0, "R4 fill");
    check(mem[50] === 32'hA000_0032, "R4 memory untouched", mem[50], 32'hA000_0032);
    access(0, 0, 32'hC8, 0, 4'hF, 32'h1122_3344, "R4 merged data");
    traffic(0, 0, "R4 hit after fill");
    // R5 byte-enable merge on copyback hit
    access(1, 0, 32'hC8, 32'h0000_AA00, 4'b0010, 0, "R5");
    traffic(0, 0, "R5 write hit");
    access(0, 0, 32'hC8, 0, 4'hF, 32'h1122_AA44, "R5 byte merge");
    // R6 dirty eviction
    access(0, 0, 32'h40, 0, 4'hF, 32'hA000_0010, "R6 refill data");
    traffic(4, 4, "R6");
    check(mem[50] === 32'h1122_AA44, "R6 writeback data", mem[50], 32'h1122_AA44);
    check(mem[48] === 32'hA000_0030, "R6 writeback word0", mem[48], 32'hA000_0030);
    // R7 write-through miss
    access(1, 1, 32'h100, 32'h5555_0001, 4'hF, 0, "R7");
    traffic(0, 1, "R7");
    check(mem[64] === 32'h5555_0001, "R7 memory written", mem[64], 32'h5555_0001);
    access(0, 0, 32'h100, 0, 4'hF, 32'h5555_0001, "R7 no allocate read");
    traffic(4, 0, "R7 later read misses");
    // R8 write-through hit
    access(1, 1, 32'h104, 32'h6666_0002, 4'hF, 0, "R8");
    traffic(0, 1, "R8");
    check(mem[65] === 32'h6666_0002, "R8 memory written", mem[65], 32'h6666_0002);
    access(0, 0, 32'h104, 0, 4'hF, 32'h6666_0002, "R8 cache updated");
    traffic(0, 0, "R8 hit");
    push(3'd0);
    traffic(0, 0, "R8 R10 clean push");
    // R9 read hit on modified line with write-through flag
    access(1, 0, 32'h44, 32'h7777_0003, 4'hF, 0, "R9");
    traffic(0, 0, "R9 dirty write");
    access(0, 1, 32'h44, 0, 4'hF, 32'h7777_0003, "R9 read hit wt");
    traffic(0, 0, "R9 no writeback");
    // R10 push modified line
    push(3'd4);
    traffic(0, 4, "R10 push dirty");
    check(mem[17] === 32'h7777_0003, "R10 pushed data", mem[17], 32'h7777_0003);
    access(0, 0, 32'h44, 0, 4'hF, 32'h7777_0003, "R10 line invalid");
    traffic(4, 0, "R10 refill");
    // R11 invalidate all drops dirty data
    access(1, 0, 32'h48, 32'h8888_0004, 4'hF, 0, "R11");
    @(negedge clk); invAll = 1;
    @(negedge clk); invAll = 0;
    access(0, 0, 32'h48, 0, 4'hF, 32'hA000_0012, "R11 dirty data dropped");
    traffic(4, 0, "R11");
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule